// File: doc/BRIEF.md
# Scan-Testable Mealy Controller

This block is a four-state Mealy controller whose state flip-flops also form one serial scan chain. In functional operation the state register loads the value from the next-state logic on every clock. When scan mode is selected the same flip-flops form a shift register. Bits enter at the low end and leave at the high end, one bit per clock.

Each transition can be tested without walking the machine through its inputs to reach the source state. A test runs four steps in order:
- shift the source state in;
- drop scan mode for exactly one clock with the input pattern applied;
- sample the combinational output during that clock;
- shift the captured state out and compare it.

With the state made fully controllable and observable this way, testing the controller comes down to testing its next-state and output logic. The functional input and output are plain level signals sampled every clock. There is no valid/ready handshake, because the machine consumes one input per cycle and never stalls.

Top module: `scan_fsm`

## Requirements
- R1: While `rst_n` is low the state is 00 (idle), so `scan_out` reads 0 and `dout` follows the idle row of R7.
- R2: With `scan_en` high, each clock moves `scan_in` into state bit 0 and each bit i into bit i+1. `scan_out` always shows the top state bit, so a 2-bit state takes 2 clocks to load or to unload, top bit first out.
- R3: With `scan_en` low in state 00: `din[0]`=1 moves to 01, otherwise the state holds.
- R4: With `scan_en` low in state 01: `din[0]`=1 moves to 10; otherwise `din[1]`=1 moves to 00; otherwise the state holds.
- R5: With `scan_en` low in state 10: `din[0]`=1 moves to 11, otherwise the state holds.
- R6: With `scan_en` low in state 11: `din[1]`=1 moves to 00, otherwise the state holds.
- R7: `dout` is combinational from the current state and `din`, so it is valid during the single capture cycle:
  - `dout[0]` is 1 only when the state is 11 and `din[1]` is 1;
  - `dout[1]` equals state bit 1 XOR `din[0]`.
- R8: Shifting in a state, then one clock with `scan_en` low, then shifting out returns the next state given by R3 to R6 for that state and input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | High: state register shifts; low: it loads the next state |
| scan_in | input | 1 | Serial data into state bit 0 |
| scan_out | output | 1 | Top state bit |
| din | input | 2 | Functional input |
| dout | output | 2 | Functional Mealy output |

## Verification
A wrong state bit shows at `scan_out` at once if it is the top bit. A wrong low bit shows one shift clock later. A wrong next-state term becomes visible after the capture clock, during the two-clock unload. A fault in the output logic appears in `dout` in the same cycle the bad state or input combination is present. The bench therefore checks every state and input pair by round trips through the chain, and also checks a functional walk with no scan.

// File: rtl/fsm_scan_pkg.sv
package fsm_scan_pkg;
  parameter int STATE_W = 2;
  parameter int IN_W    = 2;
  parameter int OUT_W   = 2;
  localparam int MSB    = STATE_W - 1;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ARM  = 2'b01,
    ST_RUN  = 2'b10,
    ST_HALT = 2'b11
  } state_t;
endpackage

// File: rtl/fsm_next_logic.sv
module fsm_next_logic
  import fsm_scan_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  logic [IN_W-1:0]    din,
  output logic [STATE_W-1:0] nxt
);
  state_t s;
  always_comb begin
    s = state_t'(cur);
    nxt = cur;
    unique case (s)
      ST_IDLE: if (din[0]) nxt = ST_ARM;
      ST_ARM: begin
        if (din[0])      nxt = ST_RUN;
        else if (din[1]) nxt = ST_IDLE;
      end
      ST_RUN:  if (din[0]) nxt = ST_HALT;
      ST_HALT: if (din[1]) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/fsm_out_logic.sv
module fsm_out_logic
  import fsm_scan_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  logic [IN_W-1:0]    din,
  output logic [OUT_W-1:0]   dout
);
  always_comb begin
    dout[0] = (cur == ST_HALT) && din[1];
    dout[1] = cur[1] ^ din[0];
  end
endmodule

// File: rtl/scan_state_reg.sv
module scan_state_reg
  import fsm_scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               scan_in,
  input  logic [STATE_W-1:0] d_func,
  output logic [STATE_W-1:0] q
);
  for (genvar i = 0; i < STATE_W; i++) begin : g_cell
    logic shift_src;
    if (i == 0) begin : g_head
      assign shift_src = scan_in;
    end else begin : g_link
      assign shift_src = q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= scan_en ? shift_src : d_func[i];
    end

    // R2: in scan mode each cell takes its chain predecessor
    if (i > 0) begin : g_chk
      a_r2_chain_link: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> q[i] == $past(q[i-1]));
    end else begin : g_chk0
      a_r2_chain_head: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> q[0] == $past(scan_in));
    end
  end

  // R8: a capture clock loads the functional next state
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> q == $past(d_func));
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import fsm_scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic            scan_in,
  output logic            scan_out,
  input  logic [IN_W-1:0] din,
  output logic [OUT_W-1:0] dout
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;

  fsm_next_logic u_next (.cur(state_q), .din(din), .nxt(state_d));
  fsm_out_logic  u_out  (.cur(state_q), .din(din), .dout(dout));
  scan_state_reg u_reg  (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .d_func(state_d), .q(state_q)
  );

  assign scan_out = state_q[MSB];

  // R3: idle holds without din[0]
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && state_q == ST_IDLE && !din[0]) |=> state_q == ST_IDLE);
  // R6: halt exits to idle on din[1]
  a_r6_halt_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && state_q == ST_HALT && din[1]) |=> state_q == ST_IDLE);
  // R5: run never falls back to a lower state
  a_r5_run_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && state_q == ST_RUN) |=> state_q[1]);
  // R7: exit pulse only alongside the halt-to-idle transition
  a_r7_pulse_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && dout[0]) |=> state_q == ST_IDLE);
endmodule

// File: tb/sim_scan_fsm.sv
module sim_scan_fsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0;
  logic scan_in = 1'b0;
  logic scan_out;
  logic [1:0] din = 2'b00;
  logic [1:0] dout;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  scan_fsm u0 (.clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
               .scan_out(scan_out), .din(din), .dout(dout));

  function automatic logic [1:0] exp_next(logic [1:0] s, logic [1:0] d);
    case (s)
      2'b00: return d[0] ? 2'b01 : 2'b00;
      2'b01: return d[0] ? 2'b10 : (d[1] ? 2'b00 : 2'b01);
      2'b10: return d[0] ? 2'b11 : 2'b10;
      default: return d[1] ? 2'b00 : 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] exp_out(logic [1:0] s, logic [1:0] d);
    return {s[1] ^ d[0], (s == 2'b11) && d[1]};
  endfunction

  task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic shift_in(logic [1:0] v);
    for (int i = 1; i >= 0; i--) begin
      @(negedge clk); scan_en = 1'b1; scan_in = v[i];
      @(posedge clk);
    end
  endtask

  task automatic shift_out(output logic [1:0] v);
    for (int i = 1; i >= 0; i--) begin
      @(negedge clk); scan_en = 1'b1; scan_in = 1'b0;
      #1 v[i] = scan_out;
      @(posedge clk);
    end
  endtask

  task automatic trans_test(logic [1:0] s, logic [1:0] d, string req);
    logic [1:0] got;
    shift_in(s);
    @(negedge clk); scan_en = 1'b0; din = d;
    #1 chk("R7 dout in capture", dout, exp_out(s, d));
    @(posedge clk);
    shift_out(got);
    chk(req, got, exp_next(s, d));
  endtask

  initial begin
    while (1) begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [1:0] got;
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 scan_out in reset", {1'b0, scan_out}, 2'b00);
    din = 2'b01; #1 chk("R1 dout idle row", dout, 2'b10);
    din = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    shift_out(got);
    chk("R1 unload after reset", got, 2'b00);

    // R2 pure shift round trip, ordering of bits
    shift_in(2'b10);
    #1 chk("R2 top bit on scan_out", {1'b0, scan_out}, 2'b01);
    shift_out(got); chk("R2 unload 10", got, 2'b10);
    shift_in(2'b01);
    #1 chk("R2 top bit low", {1'b0, scan_out}, 2'b00);
    shift_out(got); chk("R2 unload 01", got, 2'b01);

    // R3..R6, R8 exhaustive transitions via scan
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        trans_test(2'(s), 2'(d),
          s == 0 ? "R3 R8 idle row" : s == 1 ? "R4 R8 arm row" :
          s == 2 ? "R5 R8 run row" : "R6 R8 halt row");

    // functional walk without scan (R3 R4 R5 R6)
    rst_n = 1'b0; #1 rst_n = 1'b1;
    @(negedge clk); scan_en = 1'b0; din = 2'b01; @(posedge clk);
    @(negedge clk); #1 chk("R3 walk to 01", {1'b0, scan_out}, 2'b00);
    @(posedge clk);
    @(negedge clk); #1 chk("R4 walk to 10", {1'b0, scan_out}, 2'b01);
    @(posedge clk);
    @(negedge clk); din = 2'b00;
    #1 chk("R7 halt row no pulse", dout, 2'b10);
    @(posedge clk);
    @(negedge clk); din = 2'b10;
    #1 chk("R7 halt exit pulse", dout, 2'b11);
    @(posedge clk);
    shift_out(got); chk("R6 walk back to 00", got, 2'b00);

    // random round trips (R8)
    for (int k = 0; k < 60; k++) begin
      logic [1:0] rs, rd;
      rs = 2'($urandom); rd = 2'($urandom);
      trans_test(rs, rd, "R8 random round trip");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule